// File: doc/BRIEF.md
# Oversampled Counter Capture Sequencer

The sequencer samples a free-running 32-bit position count several times inside every bus cycle, so that a slow host frame carries a burst of finely spaced positions instead of one. An internal 64-bit nanosecond time base advances by a programmable step on every clock. From it the block derives two schedules: a frame boundary once per cycle time, and `n` evenly spaced sample instants inside each frame, where `n` is the oversampling factor. Sample instants are rounded up to the next clock.

Captures go into a back buffer. At each frame boundary a complete block of `n` samples is copied to the output register and offered on a valid/ready stream. It carries the low 32 bits of the time at which the following frame, and therefore the next block, starts. From that tag and the factor, the host can work out the capture time of every sample. The cycle time and factor are checked against a minimum sample spacing. A legal pair is adopted only at a frame boundary. When a boundary arrives and no block can be delivered, a sync-error flag is raised for the frame that follows.

Stream rules: the output block stays stable while `blk_valid` is high and `blk_ready` is low. A transfer happens on a clock edge where both are high. The block is never replaced while it is still pending. A new block that meets a pending one is discarded, and that frame is flagged.

Top module: `osc_capture_seq`

## Requirements
- R1: After reset `blk_valid`, `sync_err` and `cfg_reject` are 0, the local time is 0, the active factor is 1 and the active cycle time is DEF_CYCLE_NS. The first frame runs from time 0 to DEF_CYCLE_NS, and the block published at its end holds exactly 1 sample.
- R2: A requested pair is legal only when factor is in 1..N_MAX and cycle_ns >= factor × MIN_SUB_NS, so that the spacing is never below 10 µs. A pair exactly at the limit is legal. `cfg_reject` shows the result for the inputs of the previous clock. An illegal pair is never adopted, and the old pair stays active.
- R3: A legal requested pair becomes active only at a frame boundary. The block published at that boundary still holds the factor that was active during the frame just ended.
- R4: The local time starts at 0 and grows by `cfg_ns_step` per clock. Let S be the start time of a frame, with n and C its factor and cycle. Sample k (1-based) is the `pos_count` value at the first clock whose local time t satisfies n·(t − S) ≥ (k − 1)·C. The published `blk_count` equals n, and sample k sits at bits [32k−1 : 32(k−1)] of `blk_samples`.
- R5: `blk_next_ts` is the low 32 bits of the start time of the frame that begins at the publishing boundary plus one active cycle time, that is, the start of the frame after it. Over successive blocks it advances by exactly the active cycle time.
- R6: At most one capture happens per clock. If a boundary arrives before all n samples of the ending frame were taken, the block is discarded and `sync_err` is 1 until the next boundary. A boundary that publishes clears `sync_err`.
- R7: While `blk_valid` is high and `blk_ready` is low, the block, count and timestamp stay unchanged. A boundary meeting a pending block discards the new block and sets `sync_err`.
- R8: After an accepting edge with no boundary on it, `blk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_count | input | 32 | Running position count to sample |
| cfg_cycle_ns | input | 32 | Requested frame cycle time in ns |
| cfg_factor | input | 8 | Requested oversampling factor |
| cfg_ns_step | input | STEP_W | Nanoseconds added to the local time each clock |
| cfg_reject | output | 1 | Requested pair is not permissible |
| blk_valid | output | 1 | Output block available |
| blk_ready | input | 1 | Consumer accepts the block |
| blk_samples | output | N_MAX×32 | Samples, sample 1 in the lowest word |
| blk_count | output | CNT_W | Number of valid samples in the block |
| blk_next_ts | output | 32 | Low 32 bits of the next frame start time |
| sync_err | output | 1 | The last boundary could not deliver a block |

## Verification
The assertions assume that `cfg_ns_step` is nonzero and well below the cycle time. The active pair only changes at a frame tick, and boundaries keep arriving. The stall property assumes that the consumer lowers `blk_ready` only between edges. The bench applies every change of configuration, step and ready one time unit after a rising edge. It keeps the step at 1000 ns, under the 10 µs spacing, for every timing check. It raises the step above the spacing only in the final sync-error test, where missed captures are the intended outcome.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int TIME_W = 64;
  localparam int CYC_W  = 32;
  localparam int FAC_W  = 8;
  localparam int SMP_W  = 32;

  typedef struct packed {
    logic [CYC_W-1:0] cycle_ns;
    logic [FAC_W-1:0] factor;
  } osc_cfg_t;
endpackage

// File: rtl/osc_timebase.sv
module osc_timebase
  import osc_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  output logic [TIME_W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + TIME_W'(step);
  end
endmodule

// File: rtl/osc_cfg_guard.sv
module osc_cfg_guard
  import osc_pkg::*;
#(
  parameter int N_MAX        = 8,
  parameter int MIN_SUB_NS   = 10000,
  parameter int DEF_CYCLE_NS = 100000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  osc_cfg_t req,
  input  logic     frame_tick,
  output osc_cfg_t act,
  output osc_cfg_t cand,
  output logic     cfg_reject
);
  localparam int LIM_W = CYC_W + 32;

  logic [LIM_W-1:0] need_ns;
  logic             legal;

  // minimum cycle time for the requested factor
  assign need_ns = LIM_W'(req.factor) * LIM_W'(MIN_SUB_NS);
  assign legal   = (req.factor != '0) && (req.factor <= FAC_W'(N_MAX)) &&
                   (LIM_W'(req.cycle_ns) >= need_ns);
  assign cand    = legal ? req : act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act.cycle_ns <= CYC_W'(DEF_CYCLE_NS);
      act.factor   <= FAC_W'(1);
      cfg_reject   <= 1'b0;
    end else begin
      cfg_reject <= !legal;
      if (frame_tick) act <= cand;
    end
  end
endmodule

// File: rtl/osc_sampler.sv
module osc_sampler
  import osc_pkg::*;
#(
  parameter int N_MAX        = 8,
  parameter int DEF_CYCLE_NS = 100000,
  localparam int CNT_W       = $clog2(N_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TIME_W-1:0]      now,
  input  osc_cfg_t               act,
  input  osc_cfg_t               cand,
  input  logic [SMP_W-1:0]       pos_count,
  output logic                   frame_tick,
  output logic                   blk_full,
  output logic [N_MAX*SMP_W-1:0] back_flat,
  output logic [SMP_W-1:0]       ts_next
);
  logic [TIME_W-1:0] frame_start;
  logic [TIME_W-1:0] frame_due;
  logic [TIME_W-1:0] thresh;
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] scaled;
  logic [CNT_W-1:0]  cnt;
  logic              cap_due;
  logic [SMP_W-1:0]  back [N_MAX];

  assign frame_tick = (now >= frame_due);
  assign elapsed    = now - frame_start;
  // sample k is due once n*(t-S) reaches (k-1)*C; avoids a divider
  assign scaled     = elapsed * TIME_W'(act.factor);
  assign cap_due    = !frame_tick && (FAC_W'(cnt) < act.factor) && (scaled >= thresh);
  assign blk_full   = (FAC_W'(cnt) == act.factor);
  assign ts_next    = SMP_W'(frame_due + TIME_W'(cand.cycle_ns));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start <= '0;
      frame_due   <= TIME_W'(DEF_CYCLE_NS);
      thresh      <= '0;
      cnt         <= '0;
    end else if (frame_tick) begin
      // boundary: the new frame starts on schedule and takes sample 1 now
      frame_start <= frame_due;
      frame_due   <= frame_due + TIME_W'(cand.cycle_ns);
      thresh      <= TIME_W'(cand.cycle_ns);
      cnt         <= CNT_W'(1);
    end else if (cap_due) begin
      thresh <= thresh + TIME_W'(act.cycle_ns);
      cnt    <= cnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < N_MAX; g++) begin : g_slot
    logic wr_en;
    if (g == 0) begin : g_first
      assign wr_en = frame_tick || (cap_due && cnt == CNT_W'(0));
    end else begin : g_rest
      assign wr_en = cap_due && (cnt == CNT_W'(g));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     back[g] <= '0;
      else if (wr_en) back[g] <= pos_count;
    end
    assign back_flat[g*SMP_W +: SMP_W] = back[g];
  end
endmodule

// File: rtl/osc_capture_seq.sv
module osc_capture_seq
  import osc_pkg::*;
#(
  parameter int N_MAX        = 8,
  parameter int MIN_SUB_NS   = 10000,
  parameter int DEF_CYCLE_NS = 100000,
  parameter int STEP_W       = 16,
  localparam int CNT_W       = $clog2(N_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SMP_W-1:0]       pos_count,
  input  logic [CYC_W-1:0]       cfg_cycle_ns,
  input  logic [FAC_W-1:0]       cfg_factor,
  input  logic [STEP_W-1:0]      cfg_ns_step,
  output logic                   cfg_reject,
  output logic                   blk_valid,
  input  logic                   blk_ready,
  output logic [N_MAX*SMP_W-1:0] blk_samples,
  output logic [CNT_W-1:0]       blk_count,
  output logic [SMP_W-1:0]       blk_next_ts,
  output logic                   sync_err
);
  logic [TIME_W-1:0]      now;
  osc_cfg_t               req_cfg, act_cfg, cand_cfg;
  logic                   frame_tick, blk_full;
  logic [N_MAX*SMP_W-1:0] back_flat;
  logic [SMP_W-1:0]       ts_next;
  logic                   can_take;

  assign req_cfg.cycle_ns = cfg_cycle_ns;
  assign req_cfg.factor   = cfg_factor;

  osc_timebase #(.STEP_W(STEP_W)) u_time (
    .clk(clk), .rst_n(rst_n), .step(cfg_ns_step), .now(now)
  );

  osc_cfg_guard #(.N_MAX(N_MAX), .MIN_SUB_NS(MIN_SUB_NS), .DEF_CYCLE_NS(DEF_CYCLE_NS)) u_guard (
    .clk(clk), .rst_n(rst_n), .req(req_cfg), .frame_tick(frame_tick),
    .act(act_cfg), .cand(cand_cfg), .cfg_reject(cfg_reject)
  );

  osc_sampler #(.N_MAX(N_MAX), .DEF_CYCLE_NS(DEF_CYCLE_NS)) u_smp (
    .clk(clk), .rst_n(rst_n), .now(now), .act(act_cfg), .cand(cand_cfg),
    .pos_count(pos_count), .frame_tick(frame_tick), .blk_full(blk_full),
    .back_flat(back_flat), .ts_next(ts_next)
  );

  // the output slot is free when empty or being drained on this edge
  assign can_take = !blk_valid || blk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid   <= 1'b0;
      blk_samples <= '0;
      blk_count   <= '0;
      blk_next_ts <= '0;
      sync_err    <= 1'b0;
    end else begin
      if (blk_valid && blk_ready) blk_valid <= 1'b0;
      if (frame_tick) begin
        if (blk_full && can_take) begin
          blk_valid   <= 1'b1;
          blk_samples <= back_flat;
          blk_count   <= CNT_W'(act_cfg.factor);
          blk_next_ts <= ts_next;
          sync_err    <= 1'b0;
        end else begin
          sync_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osc_capture_chk.sv
module osc_capture_chk
  import osc_pkg::*;
#(
  parameter int N_MAX      = 8,
  parameter int MIN_SUB_NS = 10000,
  localparam int CNT_W     = $clog2(N_MAX + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_tick,
  input logic [CYC_W-1:0]       act_cycle,
  input logic [FAC_W-1:0]       act_factor,
  input logic                   blk_valid,
  input logic                   blk_ready,
  input logic [N_MAX*SMP_W-1:0] blk_samples,
  input logic [CNT_W-1:0]       blk_count,
  input logic [SMP_W-1:0]       blk_next_ts,
  input logic                   sync_err
);
  localparam int LIM_W = CYC_W + 32;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_samples) &&
                                $stable(blk_count) && $stable(blk_next_ts)); // R7

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && !frame_tick |=> !blk_valid); // R8

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_count != '0) && (int'(blk_count) <= N_MAX)); // R4

  AST_ACTIVE_PAIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_factor != '0) && (int'(act_factor) <= N_MAX) &&
    (LIM_W'(act_cycle) >= LIM_W'(act_factor) * LIM_W'(MIN_SUB_NS))); // R2

  AST_PAIR_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_factor) && $stable(act_cycle)); // R3

  AST_SYNC_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(sync_err)); // R6
endmodule

bind osc_capture_seq osc_capture_chk #(.N_MAX(N_MAX), .MIN_SUB_NS(MIN_SUB_NS)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .act_cycle(act_cfg.cycle_ns), .act_factor(act_cfg.factor),
  .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_samples(blk_samples),
  .blk_count(blk_count), .blk_next_ts(blk_next_ts), .sync_err(sync_err)
);

// File: tb/test_osc_capture_seq.sv
module test_osc_capture_seq;
  localparam int  CLK_PERIOD = 10;
  localparam int  N_MAX      = 8;
  localparam int  DEF_CYC    = 100000;
  localparam int  STEP_NS    = 1000;
  localparam int  CNT_W      = $clog2(N_MAX + 1);
  localparam int  WD_LIMIT   = 150000;
  localparam logic [31:0] OFS = 32'h1000_0000;
  localparam int  NVEC       = 9;
  // {cycle_ns, factor, legal}
  localparam logic [40:0] VEC_TAB [NVEC] = '{
    {32'd100000, 8'd8, 1'b1},
    {32'd50000,  8'd5, 1'b1},
    {32'd80000,  8'd8, 1'b1},
    {32'd79000,  8'd8, 1'b0},
    {32'd100000, 8'd9, 1'b0},
    {32'd100000, 8'd0, 1'b0},
    {32'd30000,  8'd3, 1'b1},
    {32'd123457, 8'd7, 1'b1},
    {32'd60000,  8'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_cycle_ns = 32'd100000;
  logic [7:0]  cfg_factor = 8'd4;
  logic [15:0] cfg_ns_step = 16'(STEP_NS);
  logic        blk_ready = 1'b1;
  logic [63:0] model_t;
  logic [31:0] pos_count;
  logic        cfg_reject, blk_valid, sync_err;
  logic [N_MAX*32-1:0] blk_samples;
  logic [CNT_W-1:0]    blk_count;
  logic [31:0]         blk_next_ts;

  int n_chk = 0, n_fail = 0, n_blocks = 0, clk_cnt = 0;
  bit mon_en = 1'b1;
  bit cur_legal = 1'b1;
  longint unsigned m_n = 1, m_cyc = DEF_CYC, fs = 0, bj = DEF_CYC;

  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus: the position count is the local time plus an offset
  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_t <= '0;
    else        model_t <= model_t + 64'(cfg_ns_step);
  assign pos_count = OFS + model_t[31:0];

  osc_capture_seq i_osc_capture_seq (
    .clk(clk), .rst_n(rst_n), .pos_count(pos_count),
    .cfg_cycle_ns(cfg_cycle_ns), .cfg_factor(cfg_factor), .cfg_ns_step(cfg_ns_step),
    .cfg_reject(cfg_reject), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_samples(blk_samples), .blk_count(blk_count), .blk_next_ts(blk_next_ts),
    .sync_err(sync_err)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // block monitor: checks every transferred block against the model
  always @(negedge clk) begin
    if (mon_en && rst_n && blk_valid && blk_ready) begin
      chk(blk_count == CNT_W'(m_n), "R4", "sample count", longint'(blk_count), longint'(m_n));
      for (int k = 1; k <= int'(m_n); k++) begin
        longint unsigned num, den, m, t;
        num = fs * m_n + longint'(k - 1) * m_cyc;
        den = m_n * STEP_NS;
        m = (num + den - 1) / den;
        t = m * STEP_NS;
        chk(blk_samples[(k-1)*32 +: 32] == OFS + 32'(t), "R4", "sample value",
            longint'(blk_samples[(k-1)*32 +: 32]), longint'(OFS + 32'(t)));
      end
      if (cur_legal) begin
        m_n = longint'(cfg_factor);
        m_cyc = longint'(cfg_cycle_ns);
      end
      chk(blk_next_ts == 32'(bj + m_cyc), "R5", "next frame timestamp",
          longint'(blk_next_ts), longint'(32'(bj + m_cyc)));
      chk(sync_err == 1'b0, "R6", "sync_err after good boundary", longint'(sync_err), 0);
      fs = bj;
      bj = bj + m_cyc;
      n_blocks++;
    end
  end

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt == WD_LIMIT) begin
      n_fail++;
      $display("FAIL R4 watchdog: cycles %0d expected below %0d", clk_cnt, WD_LIMIT);
      finish_run();
    end
  end

  task automatic wait_blocks(int cnt);
    int target = n_blocks + cnt;
    while (n_blocks < target) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(blk_valid == 1'b0, "R1", "blk_valid in reset", longint'(blk_valid), 0);
    chk(sync_err == 1'b0, "R1", "sync_err in reset", longint'(sync_err), 0);
    chk(cfg_reject == 1'b0, "R1", "cfg_reject in reset", longint'(cfg_reject), 0);
    rst_n = 1'b1;
    // R1: first block uses factor 1 although 4 is requested; R3 adopts 4 later
    wait_blocks(2);
    chk(m_n == 4, "R3", "factor adopted at boundary", longint'(m_n), 4);

    // table walk: each pair is applied mid-frame, then two blocks are checked
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      cfg_cycle_ns = VEC_TAB[i][40:9];
      cfg_factor   = VEC_TAB[i][8:1];
      cur_legal    = VEC_TAB[i][0];
      @(posedge clk); #1;
      chk(cfg_reject == !VEC_TAB[i][0], "R2", "cfg_reject", longint'(cfg_reject),
          longint'(!VEC_TAB[i][0]));
      wait_blocks(2);
    end

    // R7: stall across a boundary
    mon_en = 1'b0;
    @(posedge clk); #1;
    blk_ready = 1'b0;
    do @(negedge clk); while (!blk_valid);
    begin
      logic [N_MAX*32-1:0] snap_s;
      logic [31:0] snap_t;
      snap_s = blk_samples;
      snap_t = blk_next_ts;
      repeat (2 * 60 + 5) @(negedge clk);
      chk(blk_valid == 1'b1, "R7", "valid held while stalled", longint'(blk_valid), 1);
      chk(blk_next_ts == snap_t, "R7", "timestamp held", longint'(blk_next_ts), longint'(snap_t));
      chk(blk_samples == snap_s, "R7", "samples held", longint'(blk_samples[31:0]),
          longint'(snap_s[31:0]));
      chk(sync_err == 1'b1, "R7", "blocked boundary flags sync_err", longint'(sync_err), 1);
    end
    @(posedge clk); #1;
    blk_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(blk_valid == 1'b0, "R8", "valid low after accept", longint'(blk_valid), 0);
    do @(negedge clk); while (!blk_valid);
    @(negedge clk);
    chk(sync_err == 1'b0, "R6", "sync_err cleared by good boundary", longint'(sync_err), 0);

    // R6: step too coarse for 5 captures per frame
    @(posedge clk); #1;
    cfg_cycle_ns = 32'd100000;
    cfg_factor   = 8'd5;
    repeat (250) @(posedge clk);
    #1;
    cfg_ns_step = 16'd30000;
    repeat (20) @(negedge clk);
    begin
      int seen = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (blk_valid) seen++;
      end
      chk(seen == 0, "R6", "incomplete blocks discarded", longint'(seen), 0);
      chk(sync_err == 1'b1, "R6", "sync_err on incomplete block", longint'(sync_err), 1);
    end
    finish_run();
  end
endmodule